// File: doc/BRIEF.md
# Port I/O Instruction Decoder

This block sits beside the execute stage of a small 8-bit processor and carries out the two port I/O instructions. Each cycle it receives a 16-bit instruction word, the value already read from the source register and an execute strobe. It splits the word into fields and selects one of eight ports. It then produces either a register write-back (for a port read) or a write strobe with data for a peripheral (for a port write).

Two ports are populated. Port 1 reads the current value of an external random source, and a write to it reseeds that source. Port 2 is an output-only latch that drives eight LEDs. A read from any other port returns zero. A write to any other port does nothing. All results appear one clock after the execute edge. The random value is sampled at that edge.

Top module: `pio_port_decoder`

## Requirements
- R1: The instruction fields are opcode = instr[15:12], register index = instr[11:9] and port = instr[8:6]. With exec_en high and opcode 4'b1000 (port read), wb_en is high on the following cycle and wb_idx equals the register field.
- R2: A port read of port 1 returns, on wb_data in the following cycle, the rng_val present at the execute edge.
- R3: A port read of any port other than 1 returns wb_data = 8'h00.
- R4: With exec_en high and opcode 4'b1001 (port write) to port 1, seed_wr pulses high on the following cycle and seed_data equals src_val at the execute edge.
- R5: A port write to port 2 sets led_out to src_val on the following cycle. led_out keeps that value until the next write to port 2.
- R6: A port write to ports 0 and 3 to 7 raises neither seed_wr nor wb_en and leaves led_out unchanged.
- R7: An opcode other than 4'b1000 or 4'b1001 produces no wb_en and no seed_wr, and leaves led_out unchanged.
- R8: With exec_en low, no instruction has any effect on wb_en, seed_wr or led_out.
- R9: instr[5:0] has no effect on any output.
- R10: While rst_n is low, led_out is 8'h00 and wb_en and seed_wr are low.
- R11: wb_en and seed_wr are single-cycle pulses. They are low in the cycle after one in which no matching instruction was executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe for the current instruction |
| instr | input | 16 | Instruction word |
| src_val | input | 8 | Value of the source register named by the instruction |
| rng_val | input | 8 | Current value of the random source |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 3 | Destination register index |
| wb_data | output | 8 | Data to write back |
| seed_wr | output | 1 | Reseed strobe for the random source |
| seed_data | output | 8 | Seed value |
| led_out | output | 8 | LED latch contents |

## Verification
The bench sweeps every opcode, every register index and every port. It changes the ignored low bits, the source value and the random value on each step, and it also repeats the populated opcodes with the execute strobe low. These sweeps catch the likely decode faults:
- A decoder that matched only part of the opcode would treat neighbouring codes as I/O.
- A port compare that was off by one would move the seed strobe or the LED write to the wrong port.
- A read mux that did not default to zero would leak the random value through unused ports.

After every instruction the bench runs an idle cycle. This exposes strobes that stick high and LED values that drift without a write. A reset in the middle of the run checks that the latch clears without waiting for a clock edge.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_RD   = 2'd1,
    CLS_WR   = 2'd2
  } pio_cls_e;

  localparam logic [3:0] OPC_PORT_RD = 4'b1000;
  localparam logic [3:0] OPC_PORT_WR = 4'b1001;

  function automatic pio_cls_e classify(input logic [3:0] opc);
    if (opc == OPC_PORT_RD)      return CLS_RD;
    else if (opc == OPC_PORT_WR) return CLS_WR;
    else                         return CLS_NONE;
  endfunction

  function automatic logic [7:0] read_value(input logic [2:0] port,
                                            input logic [2:0] rng_port,
                                            input logic [7:0] rng);
    return (port == rng_port) ? rng : 8'h00;
  endfunction

endpackage

// File: rtl/pio_field_decode.sv
module pio_field_decode
  import pio_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int REG_W   = 3,
  parameter int PORT_W  = 3
) (
  input  logic [INSTR_W-1:0] instr,
  output pio_cls_e           cls,
  output logic [REG_W-1:0]   reg_idx,
  output logic [PORT_W-1:0]  port_idx
);
  localparam int REG_HI  = INSTR_W - OPC_W - 1;
  localparam int PORT_HI = REG_HI - REG_W;
  localparam int LOW_W   = INSTR_W - OPC_W - REG_W - PORT_W;

  logic [OPC_W-1:0] opc;
  logic             unused_low;

  assign opc        = instr[INSTR_W-1 -: OPC_W];
  assign reg_idx    = instr[REG_HI -: REG_W];
  assign port_idx   = instr[PORT_HI -: PORT_W];
  assign unused_low = ^instr[LOW_W-1:0];
  assign cls        = classify(4'(opc));
endmodule

// File: rtl/pio_port_select.sv
module pio_port_select
  import pio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PORT_W   = 3,
  parameter int RNG_PORT = 1
) (
  input  logic                     exec_en,
  input  pio_cls_e                 cls,
  input  logic [PORT_W-1:0]        port_idx,
  input  logic [DATA_W-1:0]        rng_val,
  output logic                     rd_hit,
  output logic [DATA_W-1:0]        rd_data,
  output logic [(1<<PORT_W)-1:0]   wr_hit
);
  localparam int NPORT = 1 << PORT_W;

  logic wr_go;

  assign rd_hit  = exec_en && (cls == CLS_RD);
  assign wr_go   = exec_en && (cls == CLS_WR);
  assign rd_data = DATA_W'(read_value(3'(port_idx), 3'(RNG_PORT), 8'(rng_val)));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign wr_hit[p] = wr_go && (port_idx == PORT_W'(p));
  end
endmodule

// File: rtl/pio_led_latch.sv
module pio_led_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/pio_port_decoder.sv
module pio_port_decoder
  import pio_pkg::*;
#(
  parameter int INSTR_W  = 16,
  parameter int OPC_W    = 4,
  parameter int REG_W    = 3,
  parameter int PORT_W   = 3,
  parameter int DATA_W   = 8,
  parameter int RNG_PORT = 1,
  parameter int LED_PORT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [DATA_W-1:0]  rng_val,
  output logic               wb_en,
  output logic [REG_W-1:0]   wb_idx,
  output logic [DATA_W-1:0]  wb_data,
  output logic               seed_wr,
  output logic [DATA_W-1:0]  seed_data,
  output logic [DATA_W-1:0]  led_out
);
  localparam int NPORT = 1 << PORT_W;

  pio_cls_e           cls;
  logic [REG_W-1:0]   reg_idx;
  logic [PORT_W-1:0]  port_idx;
  logic               in_hit;
  logic [DATA_W-1:0]  rd_data;
  logic [NPORT-1:0]   wr_hit;
  logic               seed_hit;
  logic               led_hit;
  logic               unused_wr;

  pio_field_decode #(
    .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W), .PORT_W(PORT_W)
  ) u_dec (
    .instr(instr), .cls(cls), .reg_idx(reg_idx), .port_idx(port_idx)
  );

  pio_port_select #(
    .DATA_W(DATA_W), .PORT_W(PORT_W), .RNG_PORT(RNG_PORT)
  ) u_sel (
    .exec_en(exec_en), .cls(cls), .port_idx(port_idx), .rng_val(rng_val),
    .rd_hit(in_hit), .rd_data(rd_data), .wr_hit(wr_hit)
  );

  assign seed_hit  = wr_hit[RNG_PORT];
  assign led_hit   = wr_hit[LED_PORT];
  assign unused_wr = ^wr_hit;

  pio_led_latch #(.DATA_W(DATA_W)) u_led (
    .clk(clk), .rst_n(rst_n), .wr(led_hit), .din(src_val), .q(led_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      seed_wr   <= 1'b0;
      seed_data <= '0;
    end else begin
      wb_en   <= in_hit;
      seed_wr <= seed_hit;
      if (in_hit) begin
        wb_idx  <= reg_idx;
        wb_data <= rd_data;
      end
      if (seed_hit) seed_data <= src_val;
    end
  end
endmodule

module pio_port_decoder_chk #(
  parameter int INSTR_W  = 16,
  parameter int OPC_W    = 4,
  parameter int REG_W    = 3,
  parameter int PORT_W   = 3,
  parameter int DATA_W   = 8,
  parameter int RNG_PORT = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exec_en,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  src_val,
  input logic [DATA_W-1:0]  rng_val,
  input logic               in_hit,
  input logic               seed_hit,
  input logic               led_hit,
  input logic               wb_en,
  input logic [REG_W-1:0]   wb_idx,
  input logic [DATA_W-1:0]  wb_data,
  input logic               seed_wr,
  input logic [DATA_W-1:0]  seed_data,
  input logic [DATA_W-1:0]  led_out
);
  localparam int REG_HI  = INSTR_W - OPC_W - 1;
  localparam int PORT_HI = REG_HI - REG_W;

  logic [OPC_W-1:0]  c_opc;
  logic [PORT_W-1:0] c_port;
  logic              c_other;

  assign c_opc   = instr[INSTR_W-1 -: OPC_W];
  assign c_port  = instr[PORT_HI -: PORT_W];
  assign c_other = (c_opc != OPC_W'(8)) && (c_opc != OPC_W'(9));

  assert_rd_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |=> (wb_en && wb_idx == $past(instr[REG_HI -: REG_W])));

  assert_rng_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hit && c_port == PORT_W'(RNG_PORT)) |=> (wb_data == $past(rng_val)));

  assert_unused_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hit && c_port != PORT_W'(RNG_PORT)) |=> (wb_data == '0));

  assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_hit |=> (seed_wr && seed_data == $past(src_val)));

  assert_led_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    led_hit |=> (led_out == $past(src_val)));

  assert_led_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !led_hit |=> $stable(led_out));

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_hit, seed_hit, led_hit}));

  assert_bad_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && c_other) |=> (!wb_en && !seed_wr && $stable(led_out)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> (!wb_en && !seed_wr));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_hit && !seed_hit) |=> (!wb_en && !seed_wr));
endmodule

bind pio_port_decoder pio_port_decoder_chk #(
  .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W), .PORT_W(PORT_W),
  .DATA_W(DATA_W), .RNG_PORT(RNG_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
  .src_val(src_val), .rng_val(rng_val), .in_hit(in_hit),
  .seed_hit(seed_hit), .led_hit(led_hit), .wb_en(wb_en), .wb_idx(wb_idx),
  .wb_data(wb_data), .seed_wr(seed_wr), .seed_data(seed_data),
  .led_out(led_out)
);

// File: tb/sim_pio_port_decoder.sv
`timescale 1ns/1ps
module sim_pio_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  src_val = '0;
  logic [7:0]  rng_val = '0;
  logic        wb_en;
  logic [2:0]  wb_idx;
  logic [7:0]  wb_data;
  logic        seed_wr;
  logic [7:0]  seed_data;
  logic [7:0]  led_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_led = 8'h00;

  always #4 clk = ~clk;

  pio_port_decoder u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .src_val(src_val), .rng_val(rng_val), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .seed_wr(seed_wr), .seed_data(seed_data),
    .led_out(led_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic en, input logic [3:0] op, input logic [2:0] rg,
                       input logic [2:0] pt, input logic [5:0] low,
                       input logic [7:0] src, input logic [7:0] rng);
    logic is_rd, is_wr;
    is_rd = en && (op == 4'b1000);
    is_wr = en && (op == 4'b1001);
    exec_en = en;
    instr   = {op, rg, pt, low};
    src_val = src;
    rng_val = rng;
    @(negedge clk);
    chk(is_rd ? "R1 wb_en" : "R7/R8 wb_en", {7'd0, wb_en}, {7'd0, is_rd});
    if (is_rd) begin
      chk("R1 wb_idx", {5'd0, wb_idx}, {5'd0, rg});
      if (pt == 3'd1) chk("R2 rng read", wb_data, rng);
      else            chk("R3 zero read", wb_data, 8'h00);
    end
    chk("R4/R6 seed_wr", {7'd0, seed_wr}, {7'd0, is_wr && pt == 3'd1});
    if (is_wr && pt == 3'd1) chk("R4 seed_data", seed_data, src);
    if (is_wr && pt == 3'd2) exp_led = src;
    chk("R5/R6/R9 led_out", led_out, exp_led);
    exec_en = 1'b0;
    instr   = ~instr;
    src_val = ~src;
    rng_val = ~rng;
    @(negedge clk);
    chk("R11 wb_en drop", {7'd0, wb_en}, 8'h00);
    chk("R11 seed_wr drop", {7'd0, seed_wr}, 8'h00);
    chk("R5 led hold", led_out, exp_led);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 led reset", led_out, 8'h00);
    chk("R10 wb_en reset", {7'd0, wb_en}, 8'h00);
    chk("R10 seed_wr reset", {7'd0, seed_wr}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int rg = 0; rg < 8; rg++)
        for (int pt = 0; pt < 8; pt++)
          issue(1'b1, 4'(op), 3'(rg), 3'(pt), 6'((op * 7 + rg * 3 + pt) ^ 42),
                8'(op * 37 + rg * 11 + pt * 5 + 3), 8'(op * 13 + rg * 29 + pt * 71 + 1));

    for (int op = 8; op < 10; op++)
      for (int pt = 0; pt < 8; pt++)
        issue(1'b0, 4'(op), 3'(pt), 3'(pt), 6'(pt), 8'(pt * 19 + 200), 8'(pt * 23 + 5));

    // R9: same write with different low bits gives the same LED value
    for (int lw = 0; lw < 64; lw += 9) begin
      issue(1'b1, 4'b1001, 3'd4, 3'd2, 6'(lw), 8'hA5, 8'h00);
      issue(1'b1, 4'b1000, 3'd5, 3'd1, 6'(63 - lw), 8'h00, 8'h3C);
    end

    // R10: mid-run reset clears latch asynchronously
    issue(1'b1, 4'b1001, 3'd0, 3'd2, 6'd0, 8'hFF, 8'h00);
    #1 rst_n = 1'b0;
    #1;
    exp_led = 8'h00;
    chk("R10 async led clear", led_out, 8'h00);
    chk("R10 async wb_en clear", {7'd0, wb_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 led after reset", led_out, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule